// File: doc/BRIEF.md
# Phase-Locked Gate Pulse Sequencer

This block drives the gate of one thyristor leg in a controlled rectifier. A square wave derived from the mains voltage marks the start of each electrical cycle. On every rising edge of that wave the block starts a train of four gate pulses. Each pulse has a fixed width. The first pulse comes a programmable firing delay after the edge, and the other three follow at a programmable spacing. Moving the delay moves the whole train, and that sets the firing angle.

A large delay can push the fourth pulse past the next reference edge. When that happens the block does not drop the pending pulse. It fires the pulse on time and keeps a carried-over gap, so the next train's first pulse still lands at the requested angle after its own edge. A reference edge that arrives earlier in a train is an overrun: the block abandons the train, starts a new one and raises a one-cycle flag.

Top module: `firing_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gate_out`, `busy` and `overrun` are 0 and `seq_state` is 0.
- R2: The reference passes through a two-flop synchronizer. Only a low-to-high transition of the synchronized level counts as an edge, and an edge is acted on two clocks after the first clock that samples the reference high. A level held high, or a falling edge, starts nothing.
- R3: Take k as the first clock edge that samples `ref_in` high. Pulse 1 of the train starts (`gate_out` rises) at clock edge k + D + 3, where D is `delay_cnt` sampled when the edge is acted on.
- R4: Pulses 2, 3 and 4 start S, 2S and 3S clocks after pulse 1, where S is `spacing_cnt` sampled with D. A value of S = 0 is treated as 1.
- R5: Each pulse holds `gate_out` high for exactly PULSE_LEN clocks. A pulse that starts while the gate is still high restarts the width count.
- R6: `seq_state` reads 0 when no pulse is pending, 1 to 4 while waiting for pulse 1 to 4, and 5 while waiting for a late pulse 4 after the next edge has been accepted. `busy` is 1 exactly when `seq_state` is not 0.
- R7: An edge accepted while only pulse 4 is pending moves the block to state 5. Pulse 4 still fires at its original time. The new pulse 1 starts at the time R3 gives for the new edge, or one clock after the late pulse 4 if that is later.
- R8: An edge accepted in the same cycle that the state-4 pulse fires starts a normal new train with no overrun.
- R9: An edge accepted while waiting for pulse 1, 2 or 3, or in state 5, abandons the pending pulses, starts a new train from that edge and drives `overrun` high for one clock.
- R10: Changes of `delay_cnt` or `spacing_cnt` between edges do not affect the train in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (timebase tick) |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Mains-derived square-wave reference, asynchronous |
| delay_cnt | input | CNT_W | Firing delay D in clocks |
| spacing_cnt | input | CNT_W | Pulse-to-pulse spacing S in clocks |
| gate_out | output | 1 | Gate pulse |
| busy | output | 1 | A pulse is still pending |
| seq_state | output | 3 | Sequencing state code 0 to 5 |
| overrun | output | 1 | One-cycle flag: a train was abandoned |

## Verification
The assertions check, on every cycle, the things that are local in time. A fire event is always followed by a high gate, and the gate never stays high longer than the pulse width. Accepted edges are never back to back. Every overrun follows an accepted edge. An edge in state 4 lands in state 5 or starts a clean train, depending on whether pulse 4 fires in that cycle. Only the bench scenarios can show where pulses fall in absolute time. Those scenarios cover the delay and spacing of a train, the carried-over gap after a late pulse 4 (including the case where the gap is clamped), edges that coincide with pulse 4, overruns from states 2 and 5, and inputs that change in the middle of a train.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_P1   = 3'd1,
    ST_P2   = 3'd2,
    ST_P3   = 3'd3,
    ST_P4   = 3'd4,
    ST_LATE = 3'd5
  } seq_st_t;

  // State reached once the pulse awaited in state s has fired.
  function automatic seq_st_t after_fire(input seq_st_t s);
    case (s)
      ST_P1:   return ST_P2;
      ST_P2:   return ST_P3;
      ST_P3:   return ST_P4;
      ST_LATE: return ST_P1;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/fs_edge_sync.sv
module fs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic edge_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LAST-1:0], ref_in};
  end

  // Rising edge of the synchronized level (stage STAGES-1 vs the one after)
  assign edge_o = sh_q[LAST-1] & ~sh_q[LAST];

endmodule

// File: rtl/fs_gate_stretch.sv
module fs_gate_stretch #(
  parameter int LEN = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic gate
);
  localparam int WID_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [WID_W-1:0] RELOAD = WID_W'(LEN - 1);

  logic [WID_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate   <= 1'b0;
      left_q <= '0;
    end else if (fire) begin
      gate   <= 1'b1;
      left_q <= RELOAD;
    end else if (gate) begin
      if (left_q == '0) gate <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/fs_sequencer.sv
module fs_sequencer
  import fs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_evt,
  input  logic [CNT_W-1:0] delay_in,
  input  logic [CNT_W-1:0] spacing_in,
  output logic             fire_evt,
  output seq_st_t          state,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  // Countdown reload for a spacing value; 0 behaves as 1.
  function automatic logic [CNT_W-1:0] gap_reload(input logic [CNT_W-1:0] s);
    return (s == ZERO) ? ZERO : s - 1'b1;
  endfunction

  // Gap from a late pulse 4 to the next pulse 1, saturated at zero.
  function automatic logic [CNT_W-1:0] late_gap(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] r);
    return (d > r) ? (d - r - 1'b1) : ZERO;
  endfunction

  logic [CNT_W-1:0] remain_q, hold_q, spacing_q;
  logic [CNT_W-1:0] eff_remain, nxt_remain, nxt_hold, nxt_spacing;
  seq_st_t          eff_state, nxt_state;
  logic             nxt_overrun, active;

  assign active   = (state != ST_IDLE);
  assign fire_evt = active && (remain_q == ZERO);

  always_comb begin
    // Effect of the countdown alone
    if (fire_evt) begin
      eff_state = after_fire(state);
      if (state == ST_LATE)    eff_remain = hold_q;
      else if (state == ST_P4) eff_remain = ZERO;
      else                     eff_remain = gap_reload(spacing_q);
    end else begin
      eff_state  = state;
      eff_remain = active ? remain_q - 1'b1 : ZERO;
    end

    nxt_state   = eff_state;
    nxt_remain  = eff_remain;
    nxt_hold    = hold_q;
    nxt_spacing = spacing_q;
    nxt_overrun = 1'b0;

    // An accepted edge acts on the post-fire view of the sequence
    if (edge_evt) begin
      nxt_spacing = spacing_in;
      case (eff_state)
        ST_IDLE: begin
          nxt_state  = ST_P1;
          nxt_remain = delay_in;
        end
        ST_P4: begin
          nxt_state = ST_LATE;
          nxt_hold  = late_gap(delay_in, eff_remain);
        end
        default: begin
          nxt_state   = ST_P1;
          nxt_remain  = delay_in;
          nxt_overrun = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remain_q  <= '0;
      hold_q    <= '0;
      spacing_q <= '0;
      overrun   <= 1'b0;
    end else begin
      state     <= nxt_state;
      remain_q  <= nxt_remain;
      hold_q    <= nxt_hold;
      spacing_q <= nxt_spacing;
      overrun   <= nxt_overrun;
    end
  end

endmodule

// File: rtl/firing_sequencer.sv
module firing_sequencer
  import fs_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 1000,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic [CNT_W-1:0] delay_cnt,
  input  logic [CNT_W-1:0] spacing_cnt,
  output logic             gate_out,
  output logic             busy,
  output logic [2:0]       seq_state,
  output logic             overrun
);
  logic    edge_evt;
  logic    fire_evt;
  seq_st_t state;

  fs_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .edge_o (edge_evt)
  );

  fs_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_evt   (edge_evt),
    .delay_in   (delay_cnt),
    .spacing_in (spacing_cnt),
    .fire_evt   (fire_evt),
    .state      (state),
    .overrun    (overrun)
  );

  fs_gate_stretch #(.LEN(PULSE_LEN)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire_evt),
    .gate  (gate_out)
  );

  assign seq_state = state;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int LEN = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_out,
  input logic       overrun,
  input logic [2:0] seq_state,
  input logic       edge_evt,
  input logic       fire_evt
);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (fire_evt) run_q <= 32'd1;
    else if (gate_out) run_q <= run_q + 32'd1;
    else               run_q <= '0;
  end

  // R5
  gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> gate_out);

  // R5
  gate_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out |-> (run_q <= LEN));

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out && run_q < LEN) |=> gate_out);

  // R2
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> !edge_evt);

  // R9
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(edge_evt));

  // R6
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 3'd5);

  // R7
  late_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && seq_state == 3'd4 && !fire_evt) |=> (seq_state == 3'd5));

  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && seq_state == 3'd4 && fire_evt) |=> (seq_state == 3'd1 && !overrun));

endmodule

bind firing_sequencer fs_checker #(.LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_out  (gate_out),
  .overrun   (overrun),
  .seq_state (seq_state),
  .edge_evt  (edge_evt),
  .fire_evt  (fire_evt)
);

// File: tb/tb_firing_sequencer.sv
module tb_firing_sequencer;
  localparam int CW = 16;
  localparam int PL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_in = 1'b0;
  logic [CW-1:0] delay_cnt = '0;
  logic [CW-1:0] spacing_cnt = '0;
  logic          gate_out, busy, overrun;
  logic [2:0]    seq_state;

  firing_sequencer #(.CNT_W(CW), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .delay_cnt(delay_cnt), .spacing_cnt(spacing_cnt),
    .gate_out(gate_out), .busy(busy), .seq_state(seq_state), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int    vectors = 0;
  int    misses  = 0;
  string cur_req = "R1";

  // Behavioural reference: scheduled pulse start cycles
  int mc = 0;
  int q[$];
  int last_fire = -1000000;
  bit h0 = 0, h1 = 0, h2 = 0;
  bit exp_gate = 0, exp_busy = 0, exp_ov = 0;
  int exp_state = 0;

  task automatic sched(input int p1, input int s);
    for (int i = 0; i < 4; i++) q.push_back(p1 + i * s);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); last_fire = -1000000;
      h0 = 0; h1 = 0; h2 = 0; exp_ov = 0;
    end else begin
      bit edge_now;
      int d, s, p1;
      mc = mc + 1;
      edge_now = h1 && !h2;
      h2 = h1; h1 = h0; h0 = ref_in;
      if (q.size() > 0 && q[0] == mc) begin
        void'(q.pop_front());
        last_fire = mc;
      end
      exp_ov = 0;
      if (edge_now) begin
        d = int'(delay_cnt);
        s = (spacing_cnt == 0) ? 1 : int'(spacing_cnt);
        p1 = mc + d + 1;
        if (q.size() == 1) begin
          if (q[0] + 1 > p1) p1 = q[0] + 1;
        end else if (q.size() > 1) begin
          q.delete();
          exp_ov = 1;
        end
        sched(p1, s);
      end
    end
    exp_gate  = (mc >= last_fire) && (mc <= last_fire + PL - 1);
    exp_busy  = (q.size() != 0);
    exp_state = (q.size() == 0) ? 0 : (q.size() == 5) ? 5 : 5 - q.size();
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d (t=%0d)", tag, got, exp, mc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({"R5 gate ", cur_req}, gate_out, exp_gate);
      chk({"R6 busy ", cur_req}, busy, exp_busy);
      chk({"R6 state ", cur_req}, seq_state, exp_state);
      chk({"R9 overrun ", cur_req}, overrun, exp_ov);
    end
  end

  task automatic wait_to(input int t);
    while (mc < t) @(negedge clk);
  endtask

  // Reference rise such that the edge is acted on at cycle t
  task automatic edge_at(input int t, input int hi);
    wait_to(t - 3);
    ref_in = 1'b1;
    repeat (hi) @(negedge clk);
    ref_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (gate_out !== 1'b0 || busy !== 1'b0 || seq_state !== 3'd0 || overrun !== 1'b0) begin
      misses++;
      $display("FAIL R1: got %b%b%0d%b expected 0000", gate_out, busy, seq_state, overrun);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {gate_out, busy, overrun}, 0);

    // R2,R3: long high level, falling edge ignored
    cur_req = "R2,R3"; delay_cnt = 10; spacing_cnt = 20;
    edge_at(20, 40);
    wait_to(120);

    // R10: inputs change mid-train
    cur_req = "R10"; delay_cnt = 5; spacing_cnt = 12;
    edge_at(150, 8);
    wait_to(160); delay_cnt = 50; spacing_cnt = 3;
    wait_to(230);

    // R7: late pulse 4 then carried-over delay
    cur_req = "R7"; delay_cnt = 30; spacing_cnt = 20;
    edge_at(250, 20);
    edge_at(330, 20);
    wait_to(480);

    // R7 clamped gap with gate restart (R5)
    cur_req = "R7 clamp"; delay_cnt = 30; spacing_cnt = 20;
    edge_at(500, 20);
    delay_cnt = 2;
    edge_at(580, 10);
    wait_to(680);

    // R8: edge on the pulse 4 fire cycle
    cur_req = "R8"; delay_cnt = 10; spacing_cnt = 10;
    edge_at(700, 10);
    edge_at(741, 10);
    wait_to(830);

    // R9: overrun in state 2, then in state 5
    cur_req = "R9"; delay_cnt = 10; spacing_cnt = 20;
    edge_at(850, 10);
    edge_at(870, 10);
    edge_at(935, 2);
    edge_at(940, 10);
    wait_to(1080);

    // R4: zero spacing acts as one
    cur_req = "R4"; delay_cnt = 3; spacing_cnt = 0;
    edge_at(1100, 10);
    wait_to(1200);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 4);
    misses++;
    $display("FAIL R1: watchdog expired, got running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule